// File: doc/BRIEF.md
# Pattern-Driven AXI Traffic Sequencer

This block is an AXI4 master that produces programmable memory traffic for bandwidth and integrity testing. A table of up to sixteen entries gives each transaction a direction (read or write), a burst length and a start address. The sequencer issues the entries in order from index 0 up to a programmed last index. It then repeats the whole table a programmed number of times and stops with a done indication.

Write bursts carry pseudo-random data from a 128-bit linear-feedback shift register. Each 256-bit beat is two successive register states. A second generator with the same seed produces the expected data for reads. Any read beat that differs from it raises a sticky error flag. Both generators restart from the seed at the start of every pass. Within a pass, the n-th read beat is therefore compared with the n-th written beat.

Two 64-bit counters report the transferred beats and the cycles used by the run. A pause input holds the sequence at the next gap between transactions. The table, the last index and the pass count must stay stable while the run is active.

Top module: `axi_traffic_seq`

## Requirements
- R1: Transactions follow table indices 0, 1, …, `last_idx`, then wrap to 0. Bit i of `op_bits` selects the direction of entry i: 1 is a write on the AW/W/B channels, 0 is a read on the AR/R channels.
- R2: Each address handshake carries the address of its entry (`addr_table[32*i +: 32]`) and its length value (`len_table[8*i +: 8]`, beats minus one). AxSIZE is 5 (32-byte beats) and AxBURST is 2'b01 (incrementing). WLAST is high exactly on beat number len of a write burst.
- R3: At most one transaction is outstanding. A new address handshake happens only after the B handshake of a write or the RLAST beat of a read. At least one idle cycle follows each completion.
- R4: The table is run max(1, `pass_count`) times. Then `done` rises, stays high, and no further address request is made.
- R5: Each pass starts the data generator from seed 128'h0123456789ABCDEFFEDCBA9876543210. A step shifts the state left by one and inserts s[127]^s[125]^s[100]^s[98] at bit 0. A write beat is {step(s), s}, and s then advances by two steps. `wstrb` is all ones.
- R6: Every accepted read beat is compared with the same generated sequence, restarted at each pass. Any mismatch sets `error` to 1.
- R7: Once set, `error` stays at 1 until `rst_n` is driven low.
- R8: `beat_total` counts every accepted write beat and every accepted read beat.
- R9: `cycle_total` increments on every clock edge from reset release until `done` is 1, paused cycles included. It is frozen afterwards.
- R10: While `pause` is 1, no new address request starts; a transaction already issued completes. Dropping `pause` resumes the sequence at the next entry.
- R11: While `rst_n` is 0, all valid/ready outputs, `done`, `error` and both counters are 0.
- R12: AWVALID, ARVALID and WVALID stay high with stable address or data until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; 1 lets the run start |
| pause | input | 1 | Holds the sequence between transactions |
| op_bits | input | 16 | Per-entry direction, 1 = write |
| last_idx | input | 4 | Index of the last table entry used |
| pass_count | input | 32 | Number of table passes, 0 treated as 1 |
| len_table | input | 128 | Packed per-entry burst length values |
| addr_table | input | 512 | Packed per-entry start addresses |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | 32 | Write address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 256 | Write data |
| wstrb | output | 32 | Write byte strobes |
| wlast | output | 1 | Last write beat |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | 32 | Read address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | 256 | Read data |
| rlast | input | 1 | Last read beat |
| done | output | 1 | Run finished |
| error | output | 1 | Sticky read-compare mismatch |
| beat_total | output | 64 | Accepted beat count |
| cycle_total | output | 64 | Run cycle count |

## Verification
The sequencer is driven with several table shapes, each against a behavioural memory:
- Paired writes and reads that alternate two by two over all sixteen entries show that the index order and direction decoding are correct.
- Strictly alternating single-entry writes and reads over several passes show that the generators restart at each pass.
- A one-entry all-write table reaches the boundary where the first index is also the last.
- Single-beat bursts place WLAST on beat zero.

Patterns run with and without random ready back-pressure, which separates correct valid holding from payload that changes early. Directed runs add the remaining cases:
- one corrupted read beat, to check that the error flag is set and stays set;
- a pause held across several gaps, to check that no request starts while the cycle count keeps running;
- a reset in the middle of a run, to check that all outputs and counters clear.

// File: rtl/ats_pkg.sv
package ats_pkg;

   localparam int LFSR_W = 128;
   localparam logic [LFSR_W-1:0] DEF_SEED = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
   localparam logic [1:0] BURST_INCR = 2'b01;

   typedef enum logic [2:0] {
      ST_GAP,
      ST_ADDR,
      ST_WDAT,
      ST_WRSP,
      ST_RDAT,
      ST_DONE
   } seq_state_e;

   function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
      return {s[LFSR_W-2:0], s[127] ^ s[125] ^ s[100] ^ s[98]};
   endfunction

endpackage

// File: rtl/ats_lfsr_beat.sv
module ats_lfsr_beat
   import ats_pkg::*;
#(
   parameter int DATA_W = 256,
   parameter logic [LFSR_W-1:0] SEED = DEF_SEED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reseed,
   input  logic              advance,
   output logic [DATA_W-1:0] beat
);

   logic [LFSR_W-1:0] state;
   logic [LFSR_W-1:0] step1;

   assign step1 = lfsr_next(state);

   initial begin
      if (DATA_W != LFSR_W && DATA_W != 2 * LFSR_W)
         $fatal(1, "ats_lfsr_beat: DATA_W must be one or two generator widths");
   end

   generate
      if (DATA_W == 2 * LFSR_W) begin : g_dual
         assign beat = {step1, state};
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       state <= SEED;
            else if (reseed)  state <= SEED;
            else if (advance) state <= lfsr_next(step1);
         end
      end else begin : g_single
         assign beat = state;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       state <= SEED;
            else if (reseed)  state <= SEED;
            else if (advance) state <= step1;
         end
      end
   endgenerate

   a_r5_seed_zero_free: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/ats_entry_pick.sv
module ats_entry_pick #(
   parameter int ENTRIES = 16,
   parameter int LEN_W   = 8,
   parameter int ADDR_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]        op_bits,
   input  logic [ENTRIES*LEN_W-1:0]  len_table,
   input  logic [ENTRIES*ADDR_W-1:0] addr_table,
   input  logic [IDX_W-1:0]          idx,
   output logic                      is_wr,
   output logic [LEN_W-1:0]          len,
   output logic [ADDR_W-1:0]         addr
);

   initial begin
      if (ENTRIES != (1 << IDX_W))
         $fatal(1, "ats_entry_pick: ENTRIES must be a power of two");
   end

   assign is_wr = op_bits[idx];
   assign len   = len_table[idx*LEN_W +: LEN_W];
   assign addr  = addr_table[idx*ADDR_W +: ADDR_W];

endmodule

// File: rtl/ats_counter.sv
module ats_counter #(
   parameter int W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);

   initial begin
      if (W < 2) $fatal(1, "ats_counter: width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/axi_traffic_seq.sv
module axi_traffic_seq
   import ats_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int LEN_W   = 8,
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 256,
   parameter int LOOP_W  = 32,
   parameter int CNT_W   = 64,
   parameter logic [LFSR_W-1:0] SEED = DEF_SEED,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int STRB_W = DATA_W / 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      pause,
   input  logic [ENTRIES-1:0]        op_bits,
   input  logic [IDX_W-1:0]          last_idx,
   input  logic [LOOP_W-1:0]         pass_count,
   input  logic [ENTRIES*LEN_W-1:0]  len_table,
   input  logic [ENTRIES*ADDR_W-1:0] addr_table,
   output logic                      awvalid,
   input  logic                      awready,
   output logic [ADDR_W-1:0]         awaddr,
   output logic [LEN_W-1:0]          awlen,
   output logic [2:0]                awsize,
   output logic [1:0]                awburst,
   output logic                      wvalid,
   input  logic                      wready,
   output logic [DATA_W-1:0]         wdata,
   output logic [STRB_W-1:0]         wstrb,
   output logic                      wlast,
   input  logic                      bvalid,
   output logic                      bready,
   output logic                      arvalid,
   input  logic                      arready,
   output logic [ADDR_W-1:0]         araddr,
   output logic [LEN_W-1:0]          arlen,
   output logic [2:0]                arsize,
   output logic [1:0]                arburst,
   input  logic                      rvalid,
   output logic                      rready,
   input  logic [DATA_W-1:0]         rdata,
   input  logic                      rlast,
   output logic                      done,
   output logic                      error,
   output logic [CNT_W-1:0]          beat_total,
   output logic [CNT_W-1:0]          cycle_total
);

   localparam logic [2:0] AX_SIZE = 3'($clog2(STRB_W));

   initial begin
      if (DATA_W % 8 != 0) $fatal(1, "axi_traffic_seq: DATA_W not byte aligned");
      if (LEN_W > 8)       $fatal(1, "axi_traffic_seq: AXI4 length is at most 8 bits");
   end

   seq_state_e           st;
   logic [IDX_W-1:0]     idx;
   logic [LOOP_W-1:0]    pass;
   logic [LEN_W-1:0]     beat;
   logic                 cur_wr;
   logic [LEN_W-1:0]     cur_len;
   logic [ADDR_W-1:0]    cur_addr;
   logic [DATA_W-1:0]    gen_w;
   logic [DATA_W-1:0]    gen_r;
   logic                 w_hs, r_hs, fin, wrap, last_pass;

   ats_entry_pick #(.ENTRIES(ENTRIES), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_pick (
      .op_bits(op_bits), .len_table(len_table), .addr_table(addr_table),
      .idx(idx), .is_wr(cur_wr), .len(cur_len), .addr(cur_addr)
   );

   assign w_hs      = wvalid && wready;
   assign r_hs      = rvalid && rready;
   assign fin       = (st == ST_WRSP && bvalid) || (st == ST_RDAT && rvalid && rlast);
   assign wrap      = fin && (idx == last_idx);
   assign last_pass = ({1'b0, pass} + 1'b1) >= {1'b0, pass_count};

   // both generators restart at each new pass
   ats_lfsr_beat #(.DATA_W(DATA_W), .SEED(SEED)) u_wgen (
      .clk(clk), .rst_n(rst_n), .reseed(wrap && !last_pass), .advance(w_hs), .beat(gen_w)
   );
   ats_lfsr_beat #(.DATA_W(DATA_W), .SEED(SEED)) u_rgen (
      .clk(clk), .rst_n(rst_n), .reseed(wrap && !last_pass), .advance(r_hs), .beat(gen_r)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_GAP;
         idx  <= '0;
         pass <= '0;
         beat <= '0;
      end else begin
         unique case (st)
            ST_GAP:  if (!pause) st <= ST_ADDR;
            ST_ADDR: begin
               beat <= '0;
               if (cur_wr && awready)       st <= ST_WDAT;
               else if (!cur_wr && arready) st <= ST_RDAT;
            end
            ST_WDAT: if (wready) begin
               beat <= beat + 1'b1;
               if (beat == cur_len) st <= ST_WRSP;
            end
            ST_WRSP, ST_RDAT: if (fin) begin
               if (!wrap) begin
                  idx <= idx + 1'b1;
                  st  <= ST_GAP;
               end else if (last_pass) begin
                  st <= ST_DONE;
               end else begin
                  idx  <= '0;
                  pass <= pass + 1'b1;
                  st   <= ST_GAP;
               end
            end
            ST_DONE: st <= ST_DONE;
            default: st <= ST_GAP;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     error <= 1'b0;
      else if (r_hs && rdata != gen_r) error <= 1'b1;
   end

   assign awvalid = (st == ST_ADDR) && cur_wr;
   assign arvalid = (st == ST_ADDR) && !cur_wr;
   assign awaddr  = cur_addr;
   assign araddr  = cur_addr;
   assign awlen   = cur_len;
   assign arlen   = cur_len;
   assign awsize  = AX_SIZE;
   assign arsize  = AX_SIZE;
   assign awburst = BURST_INCR;
   assign arburst = BURST_INCR;
   assign wvalid  = (st == ST_WDAT);
   assign wdata   = gen_w;
   assign wstrb   = '1;
   assign wlast   = wvalid && (beat == cur_len);
   assign bready  = (st == ST_WRSP);
   assign rready  = (st == ST_RDAT);
   assign done    = (st == ST_DONE);

   ats_counter #(.W(CNT_W)) u_beats (
      .clk(clk), .rst_n(rst_n), .inc(w_hs || r_hs), .cnt(beat_total)
   );
   ats_counter #(.W(CNT_W)) u_cycles (
      .clk(clk), .rst_n(rst_n), .inc(!done), .cnt(cycle_total)
   );

   a_r3_gap_after_bresp: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && bready) |=> (!awvalid && !arvalid));
   a_r3_gap_after_rlast: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid && rready && rlast) |=> (!awvalid && !arvalid));
   a_r4_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !awvalid && !arvalid && !wvalid));
   a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> error);
   a_r9_cycles_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(cycle_total));
   a_r10_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pause && !awvalid && !arvalid && !wvalid && !bready && !rready && !done)
      |=> (!awvalid && !arvalid));
   a_r12_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));
   a_r12_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlen)));
   a_r12_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wvalid && !wready) |=> (wvalid && $stable(wdata)));

endmodule

// File: tb/axi_traffic_seq_test.sv
module axi_traffic_seq_test;

   localparam logic [127:0] SEED = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
   // {op_bits[47:32], last_idx[31:28], passes[27:20], base_len[19:12], backpressure[0]}
   localparam logic [47:0] VEC [5] = '{
      {16'h3333, 4'hF, 8'd0, 8'd1, 11'd0, 1'b0},
      {16'h0005, 4'h3, 8'd3, 8'd2, 11'd0, 1'b1},
      {16'hFFFF, 4'h0, 8'd2, 8'd4, 11'd0, 1'b1},
      {16'h000F, 4'h7, 8'd1, 8'd0, 11'd0, 1'b0},
      {16'h3333, 4'hF, 8'd2, 8'd0, 11'd0, 1'b1}
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n = 1'b0, pause = 1'b0;
   logic [15:0]  op_bits = '0;
   logic [3:0]   last_idx = '0;
   logic [31:0]  pass_count = '0;
   logic [7:0]   tbl_len [16];
   logic [31:0]  tbl_addr [16];
   logic [127:0] len_table;
   logic [511:0] addr_table;
   logic awvalid, awready, wvalid, wready, wlast, bvalid, bready;
   logic arvalid, arready, rvalid, rready, rlast, done, error;
   logic [31:0]  awaddr, araddr;
   logic [7:0]   awlen, arlen;
   logic [2:0]   awsize, arsize;
   logic [1:0]   awburst, arburst;
   logic [255:0] wdata, rdata;
   logic [31:0]  wstrb;
   logic [63:0]  beat_total, cycle_total;

   for (genvar g = 0; g < 16; g++) begin : g_pack
      assign len_table[g*8 +: 8]    = tbl_len[g];
      assign addr_table[g*32 +: 32] = tbl_addr[g];
   end

   axi_traffic_seq uut (
      .clk(clk), .rst_n(rst_n), .pause(pause), .op_bits(op_bits), .last_idx(last_idx),
      .pass_count(pass_count), .len_table(len_table), .addr_table(addr_table),
      .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
      .awsize(awsize), .awburst(awburst), .wvalid(wvalid), .wready(wready),
      .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .bvalid(bvalid), .bready(bready),
      .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
      .arsize(arsize), .arburst(arburst), .rvalid(rvalid), .rready(rready),
      .rdata(rdata), .rlast(rlast), .done(done), .error(error),
      .beat_total(beat_total), .cycle_total(cycle_total)
   );

   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] nxt(input logic [127:0] s);
      return {s[126:0], s[127] ^ s[125] ^ s[100] ^ s[98]};
   endfunction

   // ---------------- behavioural memory slave ----------------
   logic [255:0] mem [1024];
   logic         bp_on = 1'b0;
   int           corrupt_at = -1;
   logic [15:0]  rng = 16'hACE1;
   logic         s_wact, s_ract;
   logic [9:0]   s_wptr, s_rptr;
   logic [7:0]   s_rcnt, s_rlen;
   int           r_seen;
   logic         go;
   assign go = !bp_on || rng[0];

   always @(posedge clk) begin
      rng <= {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
      if (!rst_n) begin
         awready <= 1'b0; wready <= 1'b0; bvalid <= 1'b0; arready <= 1'b0;
         rvalid <= 1'b0; rlast <= 1'b0; rdata <= '0; s_wact <= 1'b0; s_ract <= 1'b0;
         s_wptr <= '0; s_rptr <= '0; s_rcnt <= '0; s_rlen <= '0; r_seen <= 0;
      end else begin
         if (awvalid && awready) begin
            s_wact <= 1'b1;
            s_wptr <= awaddr[14:5];
         end
         awready <= !s_wact && !bvalid && !(awvalid && awready) && go;
         wready  <= (s_wact || (awvalid && awready)) && !(wvalid && wready && wlast) && go;
         if (wvalid && wready) begin
            mem[s_wptr] <= wdata;
            s_wptr <= s_wptr + 10'd1;
            if (wlast) s_wact <= 1'b0;
         end
         if (wvalid && wready && wlast) bvalid <= 1'b1;
         else if (bvalid && bready)     bvalid <= 1'b0;
         if (arvalid && arready) begin
            s_ract <= 1'b1;
            s_rptr <= araddr[14:5];
            s_rcnt <= '0;
            s_rlen <= arlen;
         end
         arready <= !s_ract && !(arvalid && arready) && go;
         if (rvalid && rready) begin
            rvalid <= 1'b0;
            if (rlast) s_ract <= 1'b0;
         end else if (s_ract && !rvalid && go) begin
            rvalid <= 1'b1;
            rdata  <= mem[s_rptr] ^ ((r_seen == corrupt_at) ? 256'h1 : 256'h0);
            rlast  <= (s_rcnt == s_rlen);
            s_rptr <= s_rptr + 10'd1;
            s_rcnt <= s_rcnt + 8'd1;
            r_seen <= r_seen + 1;
         end
      end
   end

   // ---------------- protocol and data monitor ----------------
   int           mon_t, outst, wb;
   logic [127:0] mw;
   logic [7:0]   cur_len;
   logic         aw_wait, ar_wait, w_wait;
   logic [31:0]  aw_prev, ar_prev;
   logic [255:0] w_prev;
   logic [63:0]  cyc_model;

   always @(posedge clk) begin
      if (!rst_n) cyc_model <= '0;
      else if (!done) cyc_model <= cyc_model + 64'd1;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         mon_t = 0; outst = 0; wb = 0; mw = SEED; cur_len = '0;
         aw_wait = 1'b0; ar_wait = 1'b0; w_wait = 1'b0;
      end else begin
         if (aw_wait) chk(awvalid && awaddr == aw_prev, "R12 aw hold", 64'(awaddr), 64'(aw_prev));
         if (ar_wait) chk(arvalid && araddr == ar_prev, "R12 ar hold", 64'(araddr), 64'(ar_prev));
         if (w_wait)  chk(wvalid && wdata == w_prev, "R12 w hold", wdata[63:0], w_prev[63:0]);
         aw_wait = awvalid && !awready; aw_prev = awaddr;
         ar_wait = arvalid && !arready; ar_prev = araddr;
         w_wait  = wvalid && !wready;   w_prev  = wdata;
         if ((awvalid && awready) || (arvalid && arready)) begin
            automatic int  ei   = mon_t % (int'(last_idx) + 1);
            automatic bit  is_w = awvalid && awready;
            chk(outst == 0, "R3 single outstanding", 64'(outst), 64'd0);
            chk(is_w == op_bits[ei], "R1 direction order", 64'(is_w), 64'(op_bits[ei]));
            chk((is_w ? awaddr : araddr) == tbl_addr[ei], "R2 address",
                64'(is_w ? awaddr : araddr), 64'(tbl_addr[ei]));
            chk((is_w ? awlen : arlen) == tbl_len[ei], "R2 length",
                64'(is_w ? awlen : arlen), 64'(tbl_len[ei]));
            chk((is_w ? {awsize, awburst} : {arsize, arburst}) == 5'b101_01, "R2 size and burst",
                64'(is_w ? {awsize, awburst} : {arsize, arburst}), 64'h15);
            if (ei == 0) mw = SEED;
            cur_len = tbl_len[ei];
            mon_t++; outst++; wb = 0;
         end
         if (wvalid && wready) begin
            chk(wdata == {nxt(mw), mw} && wstrb == '1, "R5 write data",
                wdata[63:0], mw[63:0]);
            chk(wlast == (wb == int'(cur_len)), "R2 wlast position", 64'(wlast), 64'(wb == int'(cur_len)));
            mw = nxt(nxt(mw));
            wb++;
         end
         if (rvalid && rready && rlast) outst--;
         if (bvalid && bready) outst--;
      end
   end

   // ---------------- helpers ----------------
   int exp_beats, exp_txns;

   task automatic check_reset_state();
      chk(!awvalid && !arvalid && !wvalid && !bready && !rready, "R11 valids low", 64'({awvalid, arvalid, wvalid, bready, rready}), 64'd0);
      chk(!done && !error, "R11 done and error low", 64'({done, error}), 64'd0);
      chk(beat_total == 0 && cycle_total == 0, "R11 counters zero", beat_total | cycle_total, 64'd0);
   endtask

   task automatic setup(input logic [15:0] pat, input logic [3:0] dep, input int passes,
                        input int base, input logic bp);
      automatic logic [7:0] reg_len [16];
      automatic int wr_n = 0, rd_n = 0, per = 0;
      @(negedge clk);
      rst_n = 1'b0;
      op_bits = pat; last_idx = dep; pass_count = 32'(passes); bp_on = bp;
      for (int i = 0; i < 16; i++) begin
         if (i > int'(dep)) begin
            tbl_len[i] = 8'h1F; tbl_addr[i] = 32'h0;
         end else if (pat[i]) begin
            tbl_len[i] = 8'(base + i % 3); tbl_addr[i] = 32'(wr_n * 2048);
            reg_len[wr_n] = tbl_len[i]; wr_n++;
         end else begin
            tbl_len[i] = reg_len[rd_n]; tbl_addr[i] = 32'(rd_n * 2048); rd_n++;
         end
         if (i <= int'(dep)) per += int'(tbl_len[i]) + 1;
      end
      repeat (3) @(negedge clk);
      check_reset_state();
      exp_beats = ((passes == 0) ? 1 : passes) * per;
      exp_txns  = ((passes == 0) ? 1 : passes) * (int'(dep) + 1);
      rst_n = 1'b1;
   endtask

   task automatic wait_done();
      for (int k = 0; k < 30000 && !done; k++) @(negedge clk);
      chk(done, "R4 done reached", 64'(done), 64'd1);
   endtask

   task automatic check_end(input logic exp_err);
      automatic logic [63:0] c0;
      chk(error == exp_err, "R6 error flag", 64'(error), 64'(exp_err));
      chk(beat_total == 64'(exp_beats), "R8 beat total", beat_total, 64'(exp_beats));
      chk(cycle_total == cyc_model, "R9 cycle total", cycle_total, cyc_model);
      chk(mon_t == exp_txns, "R4 transaction count", 64'(mon_t), 64'(exp_txns));
      c0 = cycle_total;
      repeat (20) @(negedge clk);
      chk(done && mon_t == exp_txns, "R4 no request after done", 64'(mon_t), 64'(exp_txns));
      chk(cycle_total == c0, "R9 frozen after done", cycle_total, c0);
   endtask

   // ---------------- watchdog ----------------
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         total++; bad++;
         $display("FAIL watchdog R4 actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      for (int i = 0; i < 16; i++) begin tbl_len[i] = 8'h1F; tbl_addr[i] = '0; end

      // table-driven patterns: R1 R2 R3 R4 R5 R6 R8 R9 R12
      for (int v = 0; v < 5; v++) begin
         setup(VEC[v][47:32], VEC[v][31:28], int'(VEC[v][27:20]), int'(VEC[v][19:12]), VEC[v][0]);
         wait_done();
         check_end(1'b0);
      end

      // R6 R7: one corrupted read beat sets the sticky error flag
      corrupt_at = 0;
      setup(16'h3333, 4'hF, 0, 1, 1'b0);
      wait_done();
      check_end(1'b1);
      repeat (10) @(negedge clk);
      chk(error, "R7 error stays set", 64'(error), 64'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!error, "R7 error clears on reset", 64'(error), 64'd0);
      corrupt_at = -1;

      // R10 R9: pause between transactions
      begin
         automatic int t0, t1;
         automatic logic [63:0] c1;
         setup(16'h0005, 4'h3, 3, 2, 1'b0);
         repeat (12) @(negedge clk);
         pause = 1'b1; t0 = mon_t;
         repeat (40) @(negedge clk);
         t1 = mon_t; c1 = cycle_total;
         repeat (40) @(negedge clk);
         chk(mon_t == t1, "R10 no request while paused", 64'(mon_t), 64'(t1));
         chk(t1 - t0 <= 1, "R10 at most the issued transaction completes", 64'(t1 - t0), 64'd1);
         chk(!awvalid && !arvalid && outst == 0, "R10 idle while paused", 64'(outst), 64'd0);
         chk(cycle_total - c1 == 64'd40, "R9 counts paused cycles", cycle_total - c1, 64'd40);
         pause = 1'b0;
         wait_done();
         check_end(1'b0);
      end

      // R11: reset in the middle of a run
      setup(16'h3333, 4'hF, 0, 3, 1'b1);
      repeat (30) @(negedge clk);
      chk(!done && beat_total != 0, "R11 run in progress", beat_total, 64'd1);
      rst_n = 1'b0;
      #1;
      check_reset_state();
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule